// File: doc/BRIEF.md
# SD Command Line Engine

This block issues one SD/MMC command on the single-wire CMD line and, when asked, collects the card's reply. The block samples the command index, the 32-bit argument and a small configuration word in the cycle of a start pulse. From them it builds the 48-bit host command frame, appends its CRC7 and shifts the frame out MSB first with the output enable raised. The design moves one CMD bit per clock, so the block's clock is the bus clock. Dividing a faster clock down to the bus rate is left to the logic around the block.

When a response is requested, the line is released after the end bit and the engine waits for the card's start bit. It then captures a short (48-bit) or long (136-bit) reply and checks its framing and CRC7. A short reply goes to the top response word. A long reply goes to all four words. A bounded wait flags a missing reply. Each exchange finishes with a short idle spacing on the line before the engine accepts the next command. Completion, a bad reply and a missing reply are kept as separate sticky status flags until the next accepted command.

Top module: `sd_cmd_engine`

## Requirements
- R1: An accepted command produces exactly 48 bits on `cmd_o` with `cmd_oe_o` high, beginning in the cycle after the start pulse, MSB first: 0, 1, the 6-bit index, the 32-bit argument, CRC7, then 1.
- R2: The CRC7 uses the polynomial x^7+x^3+1 with a zero seed over the first 40 frame bits; index 0 with argument 0 gives a last frame byte of 0x95.
- R3: A start pulse is accepted only when `cfg_i[0]` is 1 and status bit 0 is low; a pulse with `cfg_i[0]` at 0, or one arriving while busy, changes neither the line nor the frame being sent.
- R4: Status bit 0 is high from the cycle after an accepted start until the exchange ends, including the idle spacing.
- R5: With `cfg_i[4]` at 0 no reply is awaited, and status bit 0 is high for exactly 48 + NCC (default 2) cycles.
- R6: With `cfg_i[4]` at 1 and `cfg_i[6:5]` equal to 0 or 3, a 48-bit reply is captured. Reply bits 39:8 go to response word 3 (`rsp_o[127:96]`). Status bit 8 is set if the end bit is 0, the transmission bit (reply bit 46) is 1, or the CRC7 of reply bits 47:8 differs from bits 7:1.
- R7: With `cfg_i[6:5]` equal to 1, a 48-bit reply is captured as in R6 but its CRC field is not checked.
- R8: With `cfg_i[6:5]` equal to 2, a 136-bit reply is captured. Words 3, 2 and 1 take reply bits 127:96, 95:64 and 63:32. Word 0 takes bits 31:1 shifted up one place, with bit 0 forced to 0. The CRC7 of bits 127:8 must match bits 7:1, otherwise status bit 8 is set.
- R9: The reply start bit must be seen within TIMEOUT (default 64) cycles after the command end bit. If it is not, status bit 9 is set, status bit 8 stays low and the exchange ends.
- R10: Status bit 4 (done), bit 8 and bit 9 are sticky. They are cleared only by an accepted start, and bit 4 is set when status bit 0 falls.
- R11: Whenever `cmd_oe_o` is low, `cmd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, one CMD bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to issue a command |
| cmd_idx_i | input | 6 | Command index, sampled at start |
| cmd_arg_i | input | 32 | Command argument, sampled at start |
| cfg_i | input | 7 | bit 0 send, bit 4 reply wanted, bits 6:5 reply kind |
| cmd_i | input | 1 | Sampled CMD line |
| cmd_o | output | 1 | Value driven on CMD |
| cmd_oe_o | output | 1 | CMD output enable |
| status_o | output | 32 | bit 0 busy, bit 4 done, bit 8 reply error, bit 9 no reply |
| rsp_o | output | 128 | Four response words, word k at bits 32k+31:32k |

## Verification
The hardest conditions to reach from the ports are the edges of the reply window. A start bit arriving on the last permitted wait cycle must be accepted, and one arriving a cycle later must not. The bench plays the card itself and counts the idle cycles it inserts before its reply, so it can put the start bit on cycle 64 and then on cycle 65. It also builds replies with a single field spoiled (CRC, end bit, transmission bit). A start pulse is injected in the middle of a frame, so the ignore rule is checked against the bits already being shifted out.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_WAIT,
        ST_RX,
        ST_GAP
    } cmd_state_e;

    localparam logic [1:0] KIND_SHORT = 2'd0;
    localparam logic [1:0] KIND_NOCRC = 2'd1;
    localparam logic [1:0] KIND_LONG  = 2'd2;

    // Widest vector the CRC helper accepts.
    localparam int VEC_MAX = 136;

    // Serial CRC7 (x^7 + x^3 + 1), zero seed, over v[nbits-1:0] MSB first.
    function automatic logic [6:0] crc7_over(input logic [VEC_MAX-1:0] v, input int nbits);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = VEC_MAX - 1; i >= 0; i--) begin
            if (i < nbits) begin
                fb = v[i] ^ c[6];
                c  = {c[5:0], 1'b0};
                if (fb) c = c ^ 7'h09;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_frame_gen.sv
module sdcmd_frame_gen
    import sdcmd_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32,
    localparam int HDR_W   = 2 + IDX_W + ARG_W,
    localparam int FRAME_W = HDR_W + 8
) (
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [ARG_W-1:0]   arg_i,
    output logic [FRAME_W-1:0] frame_o
);

    logic [HDR_W-1:0] hdr;
    logic [6:0]       crc;

    // Start bit 0, host-direction bit 1, then index and argument.
    assign hdr     = {2'b01, idx_i, arg_i};
    assign crc     = crc7_over(VEC_MAX'(hdr), HDR_W);
    assign frame_o = {hdr, crc, 1'b1};

endmodule

// File: rtl/sdcmd_rsp_chk.sv
module sdcmd_rsp_chk
    import sdcmd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    localparam int SHORT_W = WORD_W + 16,
    localparam int LONG_W  = WORD_W * NWORDS + 8
) (
    input  logic [LONG_W-1:0]               frame_i,
    input  logic [1:0]                      kind_i,
    output logic                            err_o,
    output logic [NWORDS-1:0][WORD_W-1:0]   words_o
);

    logic [6:0] crc_short;
    logic [6:0] crc_long;
    logic       hdr_unused;

    assign crc_short  = crc7_over(VEC_MAX'(frame_i[SHORT_W-1:8]), SHORT_W - 8);
    assign crc_long   = crc7_over(VEC_MAX'(frame_i[LONG_W-9:8]), LONG_W - 16);
    // Long-reply start bit and reserved field carry no checked content.
    assign hdr_unused = ^{frame_i[LONG_W-1], frame_i[LONG_W-3:LONG_W-8]};

    always_comb begin
        words_o = '0;
        if (kind_i == KIND_LONG) begin
            for (int k = 1; k < NWORDS; k++) begin
                words_o[k] = frame_i[WORD_W*k +: WORD_W];
            end
            words_o[0] = {frame_i[WORD_W-1:1], 1'b0};
            err_o = !frame_i[0] || frame_i[LONG_W-2] || (crc_long != frame_i[7:1]);
        end else begin
            words_o[NWORDS-1] = frame_i[8 +: WORD_W];
            err_o = !frame_i[0] || frame_i[SHORT_W-2] ||
                    ((kind_i != KIND_NOCRC) && (crc_short != frame_i[7:1]));
        end
    end

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sdcmd_pkg::*;
#(
    parameter int IDX_W   = 6,
    parameter int ARG_W   = 32,
    parameter int WORD_W  = 32,
    parameter int NWORDS  = 4,
    parameter int CFG_W   = 7,
    parameter int STAT_W  = 32,
    parameter int TIMEOUT = 64,
    parameter int NCC     = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       start_i,
    input  logic [IDX_W-1:0]           cmd_idx_i,
    input  logic [ARG_W-1:0]           cmd_arg_i,
    input  logic [CFG_W-1:0]           cfg_i,
    input  logic                       cmd_i,
    output logic                       cmd_o,
    output logic                       cmd_oe_o,
    output logic [STAT_W-1:0]          status_o,
    output logic [NWORDS*WORD_W-1:0]   rsp_o
);

    localparam int FRAME_W = IDX_W + ARG_W + 10;
    localparam int SHORT_W = WORD_W + 16;
    localparam int LONG_W  = WORD_W * NWORDS + 8;
    localparam int MAX_A   = (FRAME_W > LONG_W) ? FRAME_W : LONG_W;
    localparam int MAX_B   = (TIMEOUT > NCC) ? TIMEOUT : NCC;
    localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    localparam int CFG_SEND  = 0;
    localparam int CFG_RSPEN = 4;
    localparam int CFG_KIND  = 5;
    localparam int ST_BUSY_B = 0;
    localparam int ST_DONE_B = 4;
    localparam int ST_RERR_B = 8;
    localparam int ST_NRSP_B = 9;

    typedef struct packed {
        cmd_state_e                 st;
        logic [FRAME_W-1:0]         tx;
        logic [CNT_W-1:0]           cnt;
        logic [LONG_W-2:0]          rx;
        logic [1:0]                 kind;
        logic                       rsp_en;
        logic                       done;
        logic                       rerr;
        logic                       nrsp;
        logic [NWORDS*WORD_W-1:0]   rsp;
    } eng_t;

    eng_t q, d;

    logic [FRAME_W-1:0]               frame;
    logic [LONG_W-1:0]                rx_frame;
    logic                             chk_err;
    logic [NWORDS-1:0][WORD_W-1:0]    chk_words;
    logic [CNT_W-1:0]                 rx_last;
    logic                             accept;
    logic                             cfg_unused;

    assign cfg_unused = ^cfg_i[CFG_RSPEN-1:CFG_SEND+1];

    sdcmd_frame_gen #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_frame (
        .idx_i   (cmd_idx_i),
        .arg_i   (cmd_arg_i),
        .frame_o (frame)
    );

    assign rx_frame = {q.rx, cmd_i};

    sdcmd_rsp_chk #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_chk (
        .frame_i (rx_frame),
        .kind_i  (q.kind),
        .err_o   (chk_err),
        .words_o (chk_words)
    );

    assign rx_last = (q.kind == KIND_LONG) ? CNT_W'(LONG_W - 1) : CNT_W'(SHORT_W - 1);
    assign accept  = start_i && cfg_i[CFG_SEND] && (q.st == ST_IDLE);

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st     = ST_TX;
                    d.tx     = frame;
                    d.cnt    = '0;
                    d.rx     = '0;
                    d.rsp_en = cfg_i[CFG_RSPEN];
                    d.kind   = cfg_i[CFG_KIND +: 2];
                    d.done   = 1'b0;
                    d.rerr   = 1'b0;
                    d.nrsp   = 1'b0;
                end
            end
            ST_TX: begin
                d.tx = {q.tx[FRAME_W-2:0], 1'b1};
                if (q.cnt == CNT_W'(FRAME_W - 1)) begin
                    d.cnt = '0;
                    d.st  = q.rsp_en ? ST_WAIT : ST_GAP;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (!cmd_i) begin
                    d.st  = ST_RX;
                    d.rx  = {q.rx[LONG_W-3:0], cmd_i};
                    d.cnt = CNT_W'(1);
                end else if (q.cnt == CNT_W'(TIMEOUT - 1)) begin
                    d.nrsp = 1'b1;
                    d.st   = ST_GAP;
                    d.cnt  = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RX: begin
                d.rx = {q.rx[LONG_W-3:0], cmd_i};
                if (q.cnt == rx_last) begin
                    d.st   = ST_GAP;
                    d.cnt  = '0;
                    d.rerr = chk_err;
                    if (q.kind == KIND_LONG) begin
                        d.rsp = chk_words;
                    end else begin
                        d.rsp[(NWORDS-1)*WORD_W +: WORD_W] = chk_words[NWORDS-1];
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (q.cnt == CNT_W'(NCC - 1)) begin
                    d.st   = ST_IDLE;
                    d.cnt  = '0;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cmd_oe_o = (q.st == ST_TX);
    assign cmd_o    = (q.st == ST_TX) ? q.tx[FRAME_W-1] : 1'b1;
    assign rsp_o    = q.rsp;

    always_comb begin
        status_o            = '0;
        status_o[ST_BUSY_B] = (q.st != ST_IDLE);
        status_o[ST_DONE_B] = q.done;
        status_o[ST_RERR_B] = q.rerr;
        status_o[ST_NRSP_B] = q.nrsp;
    end

    // R11: a released line reads as the idle level
    assert_idle_line_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_oe_o |-> cmd_o);

    // R1: every frame opens with a 0 start bit
    assert_start_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cmd_oe_o) |-> !cmd_o);

    // R4: an accepted start raises busy and drives the line next cycle
    assert_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && cfg_i[CFG_SEND] && !status_o[ST_BUSY_B]) |=> (status_o[ST_BUSY_B] && cmd_oe_o));

    // R10: the no-reply flag holds until an accepted start
    assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[ST_NRSP_B] && !(start_i && cfg_i[CFG_SEND] && !status_o[ST_BUSY_B]))
        |=> status_o[ST_NRSP_B]);

    // R10: busy falling coincides with done being shown
    assert_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[ST_BUSY_B]) |-> status_o[ST_DONE_B]);

    // R9: a missing reply never also reports a bad reply
    assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(status_o[ST_RERR_B] && status_o[ST_NRSP_B]));

endmodule

// File: tb/sd_cmd_engine_tb_top.sv
module sd_cmd_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCC_TB     = 2;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         start_i = 1'b0;
    logic [5:0]   cmd_idx_i = '0;
    logic [31:0]  cmd_arg_i = '0;
    logic [6:0]   cfg_i = '0;
    logic         cmd_i = 1'b1;
    logic         cmd_o;
    logic         cmd_oe_o;
    logic [31:0]  status_o;
    logic [127:0] rsp_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    sd_cmd_engine dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmd_idx_i(cmd_idx_i),
        .cmd_arg_i(cmd_arg_i), .cfg_i(cfg_i), .cmd_i(cmd_i), .cmd_o(cmd_o),
        .cmd_oe_o(cmd_oe_o), .status_o(status_o), .rsp_o(rsp_o)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] bcrc(input logic [135:0] v, input int n);
        logic [6:0] c = '0;
        logic fb;
        for (int i = n - 1; i >= 0; i--) begin
            fb = v[i] ^ c[6];
            c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [6:0] mkcfg(input bit send, input bit en, input logic [1:0] kind);
        return {kind, en, 3'b000, send};
    endfunction

    // Issues a command and checks its 48 bits; returns the observed frame.
    // When inject is set, a second start with another index arrives mid-frame.
    task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [6:0] cfg,
                         input bit inject, output logic [47:0] obs);
        logic [39:0] hdr;
        logic [47:0] exp;
        int bad_bits = 0;
        int bad_ctl  = 0;
        hdr = {2'b01, idx, arg};
        exp = {hdr, bcrc({96'd0, hdr}, 40), 1'b1};
        @(negedge clk_i);
        cmd_idx_i = idx; cmd_arg_i = arg; cfg_i = cfg; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        for (int i = 0; i < 48; i++) begin
            if (i > 0) @(negedge clk_i);
            obs[47-i] = cmd_o;
            if (cmd_o !== exp[47-i]) bad_bits++;
            if (cmd_oe_o !== 1'b1 || status_o[0] !== 1'b1) bad_ctl++;
            if (i == 0) check("R10 sticky flags cleared at accept", {status_o[9], status_o[8], status_o[4]}, 3'b000);
            if (inject && i == 10) begin start_i = 1'b1; cmd_idx_i = ~idx; cmd_arg_i = ~arg; end
            if (inject && i == 11) start_i = 1'b0;
        end
        check(inject ? "R3 frame unchanged by start while busy" : "R1 R2 frame bits", obs, exp);
        check("R1 R4 enable and busy held over frame", bad_ctl, 0);
    endtask

    task automatic card_reply(input int delay, input logic [135:0] f, input int len);
        repeat (delay) begin @(negedge clk_i); cmd_i = 1'b1; end
        for (int i = len - 1; i >= 0; i--) begin @(negedge clk_i); cmd_i = f[i]; end
        @(negedge clk_i);
        cmd_i = 1'b1;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (status_o[0] === 1'b1 && n < 400) begin @(negedge clk_i); n++; end
    endtask

    function automatic logic [135:0] short_frame(input logic [31:0] p, input int spoil);
        logic [39:0] h;
        logic [47:0] f;
        h = {1'b0, 1'b0, 6'h11, p};
        f = {h, bcrc({96'd0, h}, 40), 1'b1};
        if (spoil == 1) f[3] = ~f[3];
        if (spoil == 2) f[0] = 1'b0;
        if (spoil == 3) f[46] = 1'b1;
        return {88'd0, f};
    endfunction

    function automatic logic [135:0] long_frame(input logic [119:0] p, input bit spoil);
        logic [135:0] f;
        f = {2'b00, 6'h3F, p, bcrc({16'd0, p}, 120), 1'b1};
        if (spoil) f[5] = ~f[5];
        return f;
    endfunction

    initial begin
        repeat (200000) @(posedge clk_i);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [47:0]  obs;
        logic [135:0] f;
        int n;

        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R11 reset state line", {cmd_oe_o, cmd_o}, 2'b01);
        check("R10 reset status", status_o, 32'd0);
        check("R8 reset response words", rsp_o, 128'd0);

        // R2: known reference CRC values
        issue(6'd0, 32'd0, mkcfg(1, 0, 0), 0, obs);
        check("R2 index 0 arg 0 last byte", obs[7:0], 8'h95);
        wait_idle(n);
        issue(6'd8, 32'h0000_01AA, mkcfg(1, 0, 0), 0, obs);
        check("R2 index 8 arg 1AA last byte", obs[7:0], 8'h87);
        wait_idle(n);

        // R1 R5: sweep all indices without a reply
        for (int k = 0; k < 64; k++) begin
            issue(6'(k), (32'(k) * 32'h0101_0101) ^ 32'hA5C3_5A3C, mkcfg(1, 0, 0), 0, obs);
            wait_idle(n);
            check("R5 busy length 48+NCC", 48 + n - 1, 48 + NCC_TB);
            check("R10 done after no-reply command", {status_o[4], status_o[8], status_o[9]}, 3'b100);
            check("R11 line idle afterwards", {cmd_oe_o, cmd_o}, 2'b01);
        end

        // R3: start with send bit clear is ignored
        @(negedge clk_i);
        cfg_i = mkcfg(0, 1, 0); start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        check("R3 no send bit: not busy, line idle", {status_o[0], cmd_oe_o, cmd_o, status_o[4]}, 4'b0011);

        // R3: start while busy is ignored
        issue(6'd23, 32'h1234_5678, mkcfg(1, 0, 0), 1, obs);
        wait_idle(n);
        check("R3 busy length unchanged by extra start", 48 + n - 1, 48 + NCC_TB);
        repeat (3) @(negedge clk_i);
        check("R3 no second frame started", {status_o[0], cmd_oe_o}, 2'b00);

        // R6: short replies
        for (int k = 0; k < 6; k++) begin
            logic [31:0] p;
            p = 32'h0000_0900 ^ (32'(k) * 32'h3C5A_1E0F);
            issue(6'd13, 32'(k), mkcfg(1, 1, 0), 0, obs);
            card_reply(2, short_frame(p, 0), 48);
            wait_idle(n);
            check("R6 short reply word 3", rsp_o[127:96], p);
            check("R6 good short reply flags", {status_o[4], status_o[8], status_o[9]}, 3'b100);
        end
        for (int s = 1; s < 4; s++) begin
            issue(6'd13, 32'd0, mkcfg(1, 1, 0), 0, obs);
            card_reply(3, short_frame(32'hCAFE_F00D, s), 48);
            wait_idle(n);
            check("R6 spoiled short reply flags error", {status_o[8], status_o[9]}, 2'b10);
        end
        issue(6'd13, 32'd0, mkcfg(1, 1, 3), 0, obs);
        card_reply(2, short_frame(32'h1111_2222, 1), 48);
        wait_idle(n);
        check("R6 kind 3 checks CRC", status_o[8], 1'b1);

        // R7: R3-style reply, CRC ignored but framing still checked
        issue(6'd41, 32'h40FF_8000, mkcfg(1, 1, 1), 0, obs);
        card_reply(2, short_frame(32'h80FF_8000, 1), 48);
        wait_idle(n);
        check("R7 bad CRC tolerated", {status_o[8], status_o[9]}, 2'b00);
        check("R7 payload in word 3", rsp_o[127:96], 32'h80FF_8000);
        issue(6'd41, 32'd0, mkcfg(1, 1, 1), 0, obs);
        card_reply(2, short_frame(32'h80FF_8000, 2), 48);
        wait_idle(n);
        check("R7 bad end bit still flagged", status_o[8], 1'b1);

        // R8: long replies
        for (int k = 0; k < 4; k++) begin
            logic [119:0] p;
            p = {4{30'(k * 3 + 1) ^ 30'h2AB3_C1D5}};
            f = long_frame(p, 0);
            issue(6'd2, 32'd0, mkcfg(1, 1, 2), 0, obs);
            card_reply(1 + k, f, 136);
            wait_idle(n);
            check("R8 long reply words", rsp_o, {f[127:32], f[31:1], 1'b0});
            check("R8 good long reply flags", {status_o[8], status_o[9]}, 2'b00);
        end
        issue(6'd9, 32'd0, mkcfg(1, 1, 2), 0, obs);
        card_reply(2, long_frame({15{8'h5A}}, 1), 136);
        wait_idle(n);
        check("R8 spoiled long reply flagged", status_o[8], 1'b1);

        // R9: reply window boundary
        issue(6'd13, 32'd0, mkcfg(1, 1, 0), 0, obs);
        card_reply(63, short_frame(32'h0BAD_BEEF, 0), 48);
        wait_idle(n);
        check("R9 start bit on last window cycle accepted", {status_o[8], status_o[9], rsp_o[127:96]},
              {2'b00, 32'h0BAD_BEEF});
        issue(6'd13, 32'd0, mkcfg(1, 1, 0), 0, obs);
        repeat (64) begin @(negedge clk_i); cmd_i = 1'b1; end
        @(negedge clk_i);
        cmd_i = 1'b0;
        wait_idle(n);
        cmd_i = 1'b1;
        check("R9 late start bit gives no-reply", {status_o[4], status_o[8], status_o[9]}, 3'b101);
        check("R9 words kept on timeout", rsp_o[127:96], 32'h0BAD_BEEF);

        // R10: sticky hold, then cleared by next accepted start
        repeat (200) @(negedge clk_i);
        check("R10 no-reply flag held while idle", {status_o[4], status_o[9]}, 2'b11);
        issue(6'd1, 32'd0, mkcfg(1, 0, 0), 0, obs);
        wait_idle(n);
        check("R10 flags after clean command", {status_o[4], status_o[8], status_o[9]}, 3'b100);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule